// File: doc/BRIEF.md
# Privilege Level and Stack Pointer Banking Unit

This unit keeps track of a processor's execution context: whether it is servicing an exception (handler mode) or running ordinary code (thread mode), and whether thread code runs privileged or unprivileged. It holds a two-bit control register, a mode flag and two stack pointers, a main one and a process one. From these it derives the current privilege level and presents the value of whichever stack pointer is active.

Exception entry and exit arrive as one-cycle strobes. Special-register writes are requests that name a target with a two-bit selector. They are judged against the privilege level the unit holds at that moment, and an illegal one produces a one-cycle fault pulse and no state change. Ordinary stack-pointer writes always go to the pointer that is active at the time.

Top module: `priv_stack_bank`

## Requirements
- R1: After reset the unit is in privileged thread mode, `ctrl_rd` is 0, `sp_active` is 0 and `fault` is low.
- R2: An `exc_enter` strobe makes `is_handler` 1 and `is_user` 0 in the next cycle. `exc_enter` wins over a simultaneous `exc_return`, and entering while already in handler mode keeps handler mode.
- R3: An `exc_return` strobe in handler mode returns to thread mode in the next cycle. Level and stack then follow the stored control bits. An `exc_return` in thread mode has no effect.
- R4: Control bit 0 picks the thread-mode level: 0 is privileged and 1 is user (`is_user`=1). It is written by a special-register write with selector 0 that is not blocked.
- R5: Control bit 1 picks the process pointer in thread mode (1) or the main pointer (0). In handler mode `ctrl_rd[1]` reads 0 and the main pointer is active. A control write in handler mode changes bit 0 only.
- R6: Bits [1:0] of both stack pointers are always 0. Written values have those bits cleared.
- R7: A special-register write with any selector, issued while `is_user` is 1, is blocked. `fault` pulses for one cycle in the next cycle, and no register changes.
- R8: A selector-1 (execution status) write with data bit 24 clear is blocked and raises `fault`. With bit 24 set, the write is accepted without fault and has no visible effect.
- R9: Privileged selector-2 and selector-3 writes load the main and process pointers respectively. A `sp_wr_en` write loads only the currently active pointer, and it is ignored when a special-register write is requested in the same cycle.
- R10: `is_user` and `is_handler` are never 1 at the same time. `fault` is high only in a cycle that follows a special-register write request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_enter | input | 1 | Exception entry strobe |
| exc_return | input | 1 | Exception return strobe |
| sreg_wr_en | input | 1 | Special-register write request |
| sreg_wr_sel | input | 2 | Target: 0 control, 1 execution status, 2 main SP, 3 process SP |
| sreg_wr_data | input | SP_W | Special-register write data |
| sp_wr_en | input | 1 | Write to the active stack pointer |
| sp_wr_data | input | SP_W | Active stack pointer write data |
| is_user | output | 1 | Current level is unprivileged |
| is_handler | output | 1 | Current mode is handler |
| ctrl_rd | output | 2 | Control register as read (bit 1 reads 0 in handler mode) |
| sp_active | output | SP_W | Value of the active stack pointer |
| fault | output | 1 | One-cycle pulse for a blocked write |

## Verification
A wrong mode flag or control bit shows at once on `is_user`, `is_handler` or `ctrl_rd`, one cycle after the strobe or write that caused it. A pointer written into the wrong bank stays hidden until the stack selection flips. For that reason the bench switches selection and mode around every write, so that both banks become visible within a few cycles. A wrongly judged write shows as a missing or spurious `fault` pulse in the next cycle, or as a control bit or pointer that changed when it should have held.

// File: rtl/psb_pkg.sv
// Shared definitions for the privilege/stack banking unit.
// Assumes a two-bit selector naming the special-register target.
package psb_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_XSTS = 2'd1,
        SEL_MSP  = 2'd2,
        SEL_PSP  = 2'd3
    } sreg_sel_e;

    localparam int NBANK     = 2;   // main and process pointers
    localparam int BANK_MAIN = 0;
    localparam int BANK_PROC = 1;
    localparam int TBIT_POS  = 24;  // execution-state bit that must stay set
    localparam int CTRL_W    = 2;
endpackage

// File: rtl/psb_access_check.sv
// Judges a special-register write request against the current level.
// A request is blocked at user level, or when it would clear the
// execution-state bit. It then produces one write enable per target.
// Purely combinational; the caller registers the result.
module psb_access_check
    import psb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              user_lvl,
    output logic              blocked,
    output logic              ctrl_we,
    output logic              msp_we,
    output logic              psp_we
);
    sreg_sel_e sel;
    logic      tbit_clear;

    // Decode the selector and the execution-state bit.
    always_comb begin
        sel        = sreg_sel_e'(wr_sel);
        tbit_clear = (sel == SEL_XSTS) && !wr_data[TBIT_POS];
    end

    // Block illegal requests and route the legal ones to their targets.
    always_comb begin
        blocked = wr_en && (user_lvl || tbit_clear);
        ctrl_we = wr_en && !blocked && (sel == SEL_CTRL);
        msp_we  = wr_en && !blocked && (sel == SEL_MSP);
        psp_we  = wr_en && !blocked && (sel == SEL_PSP);
    end
endmodule

// File: rtl/psb_mode_track.sv
// Holds the handler/thread flag and the control register.
// Assumes that the strobes are single-cycle and that a control write has
// already been judged legal by the caller.
// In handler mode a control write updates the level bit only. The stored
// stack-select bit is kept for the return to thread mode.
module psb_mode_track
    import psb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_enter,
    input  logic              exc_return,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic              handler_q,
    output logic [CTRL_W-1:0] ctrl_q
);
    // Mode flag: entry wins over return.
    always_ff @(posedge clk) begin
        if (!rst_n)          handler_q <= 1'b0;
        else if (exc_enter)  handler_q <= 1'b1;
        else if (exc_return) handler_q <= 1'b0;
    end

    // Control register: bit 1 is held while in handler mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q[0] <= ctrl_wdata[0];
            if (!handler_q) ctrl_q[1] <= ctrl_wdata[1];
        end
    end

    // R2
    enter_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_enter |=> handler_q);

    // R3
    return_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_return && !exc_enter && !ctrl_we) |=> (!handler_q && $stable(ctrl_q)));

    // R5
    handler_sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        handler_q |=> (ctrl_q[1] == $past(ctrl_q[1])));
endmodule

// File: rtl/psb_sp_bank.sv
// Banked stack pointers with the low alignment bits forced to zero.
// Assumes at most one bank write enable is high per cycle. The read port
// returns the selected bank.
module psb_sp_bank
    import psb_pkg::*;
#(
    parameter int SP_W  = 32,
    parameter int ALIGN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBANK-1:0] bank_we,
    input  logic [SP_W-1:0]  wdata,
    input  logic             rd_sel,
    output logic [SP_W-1:0]  rd_data
);
    logic [NBANK-1:0][SP_W-1:0] sp_q;
    logic [SP_W-1:0]            wr_aligned;

    // Clear the alignment bits of the incoming value.
    always_comb wr_aligned = {wdata[SP_W-1:ALIGN], {ALIGN{1'b0}}};

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        // One pointer register per bank.
        always_ff @(posedge clk) begin
            if (!rst_n)          sp_q[g] <= '0;
            else if (bank_we[g]) sp_q[g] <= wr_aligned;
        end

        // R9
        bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !bank_we[g] |=> $stable(sp_q[g]));

        // R6
        bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bank_we[g] |=> (sp_q[g][SP_W-1:ALIGN] == $past(wdata[SP_W-1:ALIGN])
                            && sp_q[g][ALIGN-1:0] == '0));
    end

    // Select the bank for the read port.
    always_comb rd_data = sp_q[rd_sel];

    // R9
    one_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bank_we) <= 1);
endmodule

// File: rtl/priv_stack_bank.sv
// Top of the privilege-level and stack-pointer banking unit.
// Judges special-register writes, steers stack writes to the active
// bank, and produces a registered one-cycle fault pulse for blocked
// requests. Writes are judged against the mode and level held before
// the clock edge, so a write in the same cycle as a strobe uses the old
// state.
module priv_stack_bank
    import psb_pkg::*;
#(
    parameter int SP_W  = 32,
    parameter int ALIGN = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exc_enter,
    input  logic            exc_return,
    input  logic            sreg_wr_en,
    input  logic [1:0]      sreg_wr_sel,
    input  logic [SP_W-1:0] sreg_wr_data,
    input  logic            sp_wr_en,
    input  logic [SP_W-1:0] sp_wr_data,
    output logic            is_user,
    output logic            is_handler,
    output logic [1:0]      ctrl_rd,
    output logic [SP_W-1:0] sp_active,
    output logic            fault
);
    logic              handler_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              user_lvl;
    logic              use_proc;
    logic              blocked;
    logic              ctrl_we;
    logic              msp_we;
    logic              psp_we;
    logic              plain_we;
    logic [NBANK-1:0]  bank_we;
    logic [SP_W-1:0]   bank_wdata;
    logic              fault_q;

    // Derive the level and the stack selection from the mode and control bits.
    always_comb begin
        user_lvl = !handler_q && ctrl_q[0];
        use_proc = !handler_q && ctrl_q[1];
    end

    psb_access_check #(.DATA_W(SP_W)) u_check (
        .wr_en    (sreg_wr_en),
        .wr_sel   (sreg_wr_sel),
        .wr_data  (sreg_wr_data),
        .user_lvl (user_lvl),
        .blocked  (blocked),
        .ctrl_we  (ctrl_we),
        .msp_we   (msp_we),
        .psp_we   (psp_we)
    );

    psb_mode_track u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .exc_enter  (exc_enter),
        .exc_return (exc_return),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (sreg_wr_data[CTRL_W-1:0]),
        .handler_q  (handler_q),
        .ctrl_q     (ctrl_q)
    );

    // Steer writes: special-register writes take precedence over plain stack writes.
    always_comb begin
        plain_we            = sp_wr_en && !sreg_wr_en;
        bank_we[BANK_MAIN]  = msp_we || (plain_we && !use_proc);
        bank_we[BANK_PROC]  = psp_we || (plain_we && use_proc);
        bank_wdata          = sreg_wr_en ? sreg_wr_data : sp_wr_data;
    end

    psb_sp_bank #(.SP_W(SP_W), .ALIGN(ALIGN)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .bank_we (bank_we),
        .wdata   (bank_wdata),
        .rd_sel  (use_proc),
        .rd_data (sp_active)
    );

    // Register the fault pulse for a blocked request.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_q <= 1'b0;
        else        fault_q <= blocked;
    end

    // Drive the status outputs.
    always_comb begin
        is_user    = user_lvl;
        is_handler = handler_q;
        ctrl_rd    = {use_proc, ctrl_q[0]};
        fault      = fault_q;
    end

    // R10
    legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_user && is_handler));

    // R10
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $past(sreg_wr_en));

    // R7
    user_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sreg_wr_en && is_user && !exc_enter && !exc_return)
            |=> (fault && $stable(ctrl_rd) && $stable(sp_active) && $stable(is_user)));

    // R6
    sp_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp_active[ALIGN-1:0] == '0);

    // R5
    handler_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_handler |-> (ctrl_rd[1] == 1'b0));
endmodule

// File: tb/priv_stack_bank_bench.sv
// Self-checking bench: sweeps every control value, both modes, every
// selector and both values of the execution-state bit, then runs a long
// pseudo-random stream against a model built from the requirements.
module priv_stack_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SP_W = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            exc_enter = 1'b0, exc_return = 1'b0;
    logic            sreg_wr_en = 1'b0, sp_wr_en = 1'b0;
    logic [1:0]      sreg_wr_sel = 2'd0;
    logic [SP_W-1:0] sreg_wr_data = '0, sp_wr_data = '0;
    logic            is_user, is_handler, fault;
    logic [1:0]      ctrl_rd;
    logic [SP_W-1:0] sp_active;

    int checks = 0;
    int failures = 0;

    // model state
    logic            m_h = 1'b0;
    logic [1:0]      m_c = 2'b00;
    logic [SP_W-1:0] m_msp = '0, m_psp = '0;
    logic            m_f = 1'b0;
    logic [31:0]     lf = 32'h1ACE_B00C;

    always #(CLK_PERIOD/2) clk = ~clk;

    priv_stack_bank #(.SP_W(SP_W)) u_priv_stack_bank (
        .clk(clk), .rst_n(rst_n), .exc_enter(exc_enter), .exc_return(exc_return),
        .sreg_wr_en(sreg_wr_en), .sreg_wr_sel(sreg_wr_sel), .sreg_wr_data(sreg_wr_data),
        .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data), .is_user(is_user),
        .is_handler(is_handler), .ctrl_rd(ctrl_rd), .sp_active(sp_active), .fault(fault)
    );

    task automatic check(input string tag, input string what,
                         input logic [SP_W-1:0] act, input logic [SP_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Compare every output with the model.
    task automatic check_all(input string tag);
        logic use_p;
        use_p = !m_h && m_c[1];
        check(tag, "is_handler", {31'd0, is_handler}, {31'd0, m_h});
        check(tag, "is_user", {31'd0, is_user}, {31'd0, !m_h && m_c[0]});
        check(tag, "ctrl_rd", {30'd0, ctrl_rd}, {30'd0, use_p, m_c[0]});
        check(tag, "sp_active", sp_active, use_p ? m_psp : m_msp);
        check(tag, "fault", {31'd0, fault}, {31'd0, m_f});
        check("R10", "legal_state", {31'd0, is_user && is_handler}, 32'd0);
        check("R6", "sp_align", {30'd0, sp_active[1:0]}, 32'd0);
    endtask

    // Drive one cycle of stimulus, advance the model, then check.
    task automatic op(input logic en, input logic rt, input logic swe, input logic [1:0] sel,
                      input logic [SP_W-1:0] sd, input logic spwe, input logic [SP_W-1:0] spd,
                      input string tag);
        logic usr, blk, use_p;
        exc_enter = en; exc_return = rt; sreg_wr_en = swe; sreg_wr_sel = sel;
        sreg_wr_data = sd; sp_wr_en = spwe; sp_wr_data = spd;
        usr   = !m_h && m_c[0];
        use_p = !m_h && m_c[1];
        blk   = swe && (usr || (sel == 2'd1 && !sd[24]));
        m_f   = blk;
        if (swe && !blk) begin
            case (sel)
                2'd0: begin m_c[0] = sd[0]; if (!m_h) m_c[1] = sd[1]; end
                2'd2: m_msp = sd & ~32'd3;
                2'd3: m_psp = sd & ~32'd3;
                default: ;
            endcase
        end else if (!swe && spwe) begin
            if (use_p) m_psp = spd & ~32'd3;
            else       m_msp = spd & ~32'd3;
        end
        if (en)      m_h = 1'b1;
        else if (rt) m_h = 1'b0;
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic idle(input string tag);
        op(1'b0, 1'b0, 1'b0, 2'd0, '0, 1'b0, '0, tag);
    endtask

    // Bring the unit to a given control value and mode.
    task automatic goto_state(input logic [1:0] c, input logic h);
        op(1'b1, 1'b0, 1'b0, 2'd0, '0, 1'b0, '0, "R2");
        op(1'b0, 1'b0, 1'b1, 2'd0, 32'd0, 1'b0, '0, "R5");
        op(1'b0, 1'b1, 1'b0, 2'd0, '0, 1'b0, '0, "R3");
        op(1'b0, 1'b0, 1'b1, 2'd0, {30'd0, c}, 1'b0, '0, "R4");
        if (h) op(1'b1, 1'b0, 1'b0, 2'd0, '0, 1'b0, '0, "R2");
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, observed before any stimulus
        check_all("R1");
        idle("R1");

        // R3: return in thread mode does nothing
        op(1'b0, 1'b1, 1'b0, 2'd0, '0, 1'b0, '0, "R3");
        // R2: entry beats a simultaneous return; re-entry holds handler mode
        op(1'b1, 1'b1, 1'b0, 2'd0, '0, 1'b0, '0, "R2");
        op(1'b1, 1'b0, 1'b0, 2'd0, '0, 1'b0, '0, "R2");
        // R9: a plain write in handler mode lands in the main pointer
        op(1'b0, 1'b0, 1'b0, 2'd0, '0, 1'b1, 32'h0000_1237, "R9");
        op(1'b0, 1'b1, 1'b0, 2'd0, '0, 1'b0, '0, "R3");
        // R9: a plain write is dropped when a special write comes in the same cycle
        op(1'b0, 1'b0, 1'b1, 2'd3, 32'h0000_8001, 1'b1, 32'hDEAD_BEEF, "R9");
        op(1'b0, 1'b0, 1'b1, 2'd0, 32'd2, 1'b0, '0, "R5");
        // R8: execution-state bit clear faults, set passes
        op(1'b0, 1'b0, 1'b1, 2'd1, 32'h0000_0000, 1'b0, '0, "R8");
        op(1'b0, 1'b0, 1'b1, 2'd1, 32'h0100_0000, 1'b0, '0, "R8");
        // R7: drop to user level, then every write is blocked
        op(1'b0, 1'b0, 1'b1, 2'd0, 32'd3, 1'b0, '0, "R4");
        for (int s = 0; s < 4; s++)
            op(1'b0, 1'b0, 1'b1, 2'(s), 32'h0100_0000, 1'b0, '0, "R7");
        idle("R10");
        // R5: in handler mode selection reads 0; a handler control write keeps bit 1
        op(1'b1, 1'b0, 1'b0, 2'd0, '0, 1'b0, '0, "R5");
        op(1'b0, 1'b0, 1'b1, 2'd0, 32'd0, 1'b0, '0, "R5");
        op(1'b0, 1'b1, 1'b0, 2'd0, '0, 1'b0, '0, "R3");

        // Sweep: every control value, both modes, every selector, bit 24 both ways
        for (int c = 0; c < 4; c++)
            for (int h = 0; h < 2; h++)
                for (int s = 0; s < 4; s++)
                    for (int t = 0; t < 2; t++) begin
                        goto_state(2'(c), h[0]);
                        op(1'b0, 1'b0, 1'b1, 2'(s),
                           {7'd0, t[0], 8'h5A, 8'hC3, 6'd0, 2'(c ^ 3)}, 1'b0, '0,
                           (s == 1) ? "R8" : "R7");
                        op(1'b0, 1'b0, 1'b0, 2'd0, '0, 1'b1,
                           {16'h4000, 8'(c * 8 + h * 4 + s), 8'hFF}, "R9");
                        if (h == 1) op(1'b0, 1'b1, 1'b0, 2'd0, '0, 1'b0, '0, "R3");
                        idle("R10");
                    end

        // Pseudo-random stream
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            op(lf[3:0] == 4'd0, lf[7:4] == 4'd1, lf[9:8] == 2'd0, lf[11:10],
               {lf[31:16], lf[15:0] ^ 16'h0100} | ((lf[12] ? 32'h0100_0000 : 32'd0)),
               lf[13], {lf[15:0], lf[31:16]}, "R9");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule